// File: doc/BRIEF.md
# Time-Sliced Peripheral Processor Array

This block gives ten small, independent processor contexts one arithmetic datapath to share. Each context holds its own program counter, 12-bit accumulator and private word memory. A slot counter hands the shared decode and adder to one context per clock in a fixed rotation. Each context therefore advances one step every ten clocks, and its neighbours' state never moves while it is active. At a 100 ns slot, one full turn of the ring takes 1 µs.

Programs are written into each context's private memory through a preload port. This is normally done while reset is held. Software-visible progress is read back through a debug port, which returns the accumulator and program counter of any selected context.

Instructions are 12 bits (short form) or 24 bits (long form). Both forms carry a 6-bit opcode in the top bits of their first word. The long form spends two of its context's slots: the first slot fetches the upper word, and the second fetches the lower word and executes. The upper word's 6 low bits and the whole lower word together form an 18-bit address. Of that address, only the low memory-index bits are used.

Top module: `pp_barrel_array`

## Requirements
- R1: The active slot, shown on `active_ctx`, is 0 after reset and rises by one each clock from 0 to 9, then wraps back to 0.
- R2: Reset clears every context's program counter and accumulator to 0.
- R3: On each clock only the context in the active slot may change its registers and memory; every other context keeps its state.
- R4: Opcode 6'o01 (short) loads the zero-extended 6-bit low field into the accumulator and advances the program counter by one.
- R5: Opcode 6'o02 (short) adds the zero-extended 6-bit low field to the accumulator modulo 4096.
- R6: An opcode with bit 5 set is long. Its first slot only latches the upper word and steps the program counter. Its second slot reads the lower word, forms the address {upper[5:0], lower}, and keeps that address's low memory-index bits.
- R7: Opcode 6'o41 (long) loads the addressed private word into the accumulator.
- R8: Opcode 6'o42 (long) adds the addressed private word to the accumulator modulo 4096, with no carry kept.
- R9: Opcode 6'o43 (long) writes the accumulator to the addressed private word.
- R10: Opcode 6'o44 (long) sets the program counter to the truncated address.
- R11: Any other short opcode, including 6'o00, and any other long opcode change only the program counter. A short one advances it by one, and a long one advances it by two over its two slots.
- R12: Each context's memory is private: the same address in different contexts holds independent values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pl_en | input | 1 | Preload write strobe |
| pl_ctx | input | SLOT_W | Context whose memory is preloaded |
| pl_addr | input | ADDR_W | Preload word address |
| pl_data | input | 12 | Preload word |
| dbg_ctx | input | SLOT_W | Context selected for debug read |
| dbg_acc | output | 12 | Accumulator of selected context |
| dbg_pc | output | ADDR_W | Program counter of selected context |
| active_ctx | output | SLOT_W | Context owning the current slot |

## Verification
Each context runs the same program shape, but with its own immediates and its own preloaded data. A store-then-read sequence at one shared address therefore shows whether memories leak between contexts. Adds that cross 4095 separate correct modulo wrap from widening or carry leakage. Undefined short and long opcodes, together with a jump whose address has high bits set, distinguish correct length decoding and truncation from miscounted program counters. After every slot, both the active context and a context half a ring away are compared, so a write to the wrong context shows up at once.

// File: rtl/pp_pkg.sv
package pp_pkg;

    localparam int WORD_W = 12;
    localparam int OP_W   = 6;
    localparam int FLD_W  = WORD_W - OP_W;
    localparam int FAR_W  = FLD_W + WORD_W;

    typedef enum logic [OP_W-1:0] {
        OP_NOP = 6'o00,
        OP_LDI = 6'o01,
        OP_ADI = 6'o02,
        OP_LDM = 6'o41,
        OP_ADM = 6'o42,
        OP_STM = 6'o43,
        OP_JMP = 6'o44
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [FLD_W-1:0] fld;
    } iword_t;

    function automatic logic is_long(input op_e op);
        return op[OP_W-1];
    endfunction

    function automatic logic [WORD_W-1:0] add_mod(input logic [WORD_W-1:0] a,
                                                  input logic [WORD_W-1:0] b);
        return a + b;
    endfunction

    function automatic logic [FAR_W-1:0] far_addr(input iword_t hi,
                                                  input logic [WORD_W-1:0] lo);
        return {hi.fld, lo};
    endfunction

endpackage

// File: rtl/pp_slot_ring.sv
module pp_slot_ring #(
    parameter int NCTX   = 10,
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    output logic [SLOT_W-1:0] slot
);

    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NCTX - 1);

    always_ff @(posedge clk) begin
        if (rst)
            slot <= '0;
        else if (slot == LAST)
            slot <= '0;
        else
            slot <= slot + 1'b1;
    end

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (rst) slot <= LAST); // R1
    AST_SLOT_STEP:  assert property (@(posedge clk) disable iff (rst)
                        (slot != LAST) |=> (slot == $past(slot) + 1'b1)); // R1
    AST_SLOT_WRAP:  assert property (@(posedge clk) disable iff (rst)
                        (slot == LAST) |=> (slot == '0)); // R1

endmodule

// File: rtl/pp_ctx_mem.sv
module pp_ctx_mem #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_i,
    input  logic [ADDR_W-1:0] raddr_d,
    output logic [DATA_W-1:0] rdata_d
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            words[waddr] <= wdata;
    end

    assign rdata_i = words[raddr_i];
    assign rdata_d = words[raddr_d];

endmodule

// File: rtl/pp_exec_unit.sv
module pp_exec_unit
    import pp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              phase,
    input  iword_t            w0_hold,
    input  logic [WORD_W-1:0] fetch_word,
    input  logic [WORD_W-1:0] data_word,
    input  logic [WORD_W-1:0] acc,
    input  logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] data_addr,
    output logic [WORD_W-1:0] nxt_acc,
    output logic [ADDR_W-1:0] nxt_pc,
    output logic              nxt_phase,
    output iword_t            nxt_w0,
    output logic              st_en
);

    iword_t            cur;
    logic [WORD_W-1:0] operand;
    logic [WORD_W-1:0] sum;

    assign cur       = iword_t'(fetch_word);
    assign data_addr = ADDR_W'(far_addr(w0_hold, fetch_word));
    assign operand   = phase ? data_word : {{OP_W{1'b0}}, cur.fld};
    assign sum       = add_mod(acc, operand);

    always_comb begin
        nxt_acc   = acc;
        nxt_pc    = pc + 1'b1;
        nxt_phase = 1'b0;
        nxt_w0    = w0_hold;
        st_en     = 1'b0;
        if (!phase) begin
            if (is_long(cur.op)) begin
                nxt_phase = 1'b1;
                nxt_w0    = cur;
            end else begin
                case (cur.op)
                    OP_LDI:  nxt_acc = operand;
                    OP_ADI:  nxt_acc = sum;
                    default: ;
                endcase
            end
        end else begin
            case (w0_hold.op)
                OP_LDM:  nxt_acc = operand;
                OP_ADM:  nxt_acc = sum;
                OP_STM:  st_en   = 1'b1;
                OP_JMP:  nxt_pc  = data_addr;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pp_barrel_array.sv
module pp_barrel_array
    import pp_pkg::*;
#(
    parameter  int NCTX   = 10,
    parameter  int ADDR_W = 8,
    localparam int SLOT_W = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pl_en,
    input  logic [SLOT_W-1:0] pl_ctx,
    input  logic [ADDR_W-1:0] pl_addr,
    input  logic [WORD_W-1:0] pl_data,
    input  logic [SLOT_W-1:0] dbg_ctx,
    output logic [WORD_W-1:0] dbg_acc,
    output logic [ADDR_W-1:0] dbg_pc,
    output logic [SLOT_W-1:0] active_ctx
);

    logic [SLOT_W-1:0] slot;

    logic [WORD_W-1:0] acc_q   [NCTX];
    logic [ADDR_W-1:0] pc_q    [NCTX];
    logic              ph_q    [NCTX];
    iword_t            w0_q    [NCTX];
    logic [WORD_W-1:0] fetch_w [NCTX];
    logic [WORD_W-1:0] data_w  [NCTX];

    logic [WORD_W-1:0] cur_acc, cur_fetch, cur_data;
    logic [ADDR_W-1:0] cur_pc;
    logic              cur_ph;
    iword_t            cur_w0;

    logic [ADDR_W-1:0] data_addr;
    logic [WORD_W-1:0] nxt_acc;
    logic [ADDR_W-1:0] nxt_pc;
    logic              nxt_phase;
    iword_t            nxt_w0;
    logic              st_en;

    pp_slot_ring #(.NCTX(NCTX), .SLOT_W(SLOT_W)) u_ring (
        .clk  (clk),
        .rst  (rst),
        .slot (slot)
    );

    assign active_ctx = slot;

    // Route the active context onto the shared datapath.
    always_comb begin
        cur_acc   = '0;
        cur_pc    = '0;
        cur_ph    = 1'b0;
        cur_w0    = '0;
        cur_fetch = '0;
        cur_data  = '0;
        for (int i = 0; i < NCTX; i++) begin
            if (slot == SLOT_W'(i)) begin
                cur_acc   = acc_q[i];
                cur_pc    = pc_q[i];
                cur_ph    = ph_q[i];
                cur_w0    = w0_q[i];
                cur_fetch = fetch_w[i];
                cur_data  = data_w[i];
            end
        end
    end

    pp_exec_unit #(.ADDR_W(ADDR_W)) u_exec (
        .phase      (cur_ph),
        .w0_hold    (cur_w0),
        .fetch_word (cur_fetch),
        .data_word  (cur_data),
        .acc        (cur_acc),
        .pc         (cur_pc),
        .data_addr  (data_addr),
        .nxt_acc    (nxt_acc),
        .nxt_pc     (nxt_pc),
        .nxt_phase  (nxt_phase),
        .nxt_w0     (nxt_w0),
        .st_en      (st_en)
    );

    generate
        for (genvar c = 0; c < NCTX; c++) begin : g_ctx
            logic              mine;
            logic              pl_hit;
            logic              we;
            logic [ADDR_W-1:0] waddr;
            logic [WORD_W-1:0] wdata;

            assign mine   = (slot == SLOT_W'(c));
            assign pl_hit = pl_en && (pl_ctx == SLOT_W'(c));
            assign we     = pl_hit || (!rst && mine && st_en);
            assign waddr  = pl_hit ? pl_addr : data_addr;
            assign wdata  = pl_hit ? pl_data : cur_acc;

            pp_ctx_mem #(.ADDR_W(ADDR_W), .DATA_W(WORD_W)) u_mem (
                .clk     (clk),
                .we      (we),
                .waddr   (waddr),
                .wdata   (wdata),
                .raddr_i (pc_q[c]),
                .rdata_i (fetch_w[c]),
                .raddr_d (data_addr),
                .rdata_d (data_w[c])
            );

            always_ff @(posedge clk) begin
                if (rst) begin
                    acc_q[c] <= '0;
                    pc_q[c]  <= '0;
                    ph_q[c]  <= 1'b0;
                    w0_q[c]  <= '0;
                end else if (mine) begin
                    acc_q[c] <= nxt_acc;
                    pc_q[c]  <= nxt_pc;
                    ph_q[c]  <= nxt_phase;
                    w0_q[c]  <= nxt_w0;
                end
            end

            AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
                (slot != SLOT_W'(c)) |=> ($stable(acc_q[c]) && $stable(pc_q[c])
                                          && $stable(ph_q[c]))); // R3
            AST_LONG_DONE: assert property (@(posedge clk) disable iff (rst)
                (slot == SLOT_W'(c) && ph_q[c]) |=> !ph_q[c]); // R6
            AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |-> (acc_q[c] == '0 && pc_q[c] == '0)); // R2
        end
    endgenerate

    always_comb begin
        dbg_acc = '0;
        dbg_pc  = '0;
        for (int i = 0; i < NCTX; i++) begin
            if (dbg_ctx == SLOT_W'(i)) begin
                dbg_acc = acc_q[i];
                dbg_pc  = pc_q[i];
            end
        end
    end

endmodule

// File: tb/pp_barrel_array_tb.sv
`timescale 1ns/1ps
module pp_barrel_array_tb;

    localparam int NCTX  = 10;
    localparam int AW    = 8;
    localparam int SW    = 4;
    localparam int STEPS = 40;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pl_en = 1'b0;
    logic [SW-1:0] pl_ctx = '0;
    logic [AW-1:0] pl_addr = '0;
    logic [11:0]   pl_data = '0;
    logic [SW-1:0] dbg_ctx = '0;
    logic [11:0]   dbg_acc;
    logic [AW-1:0] dbg_pc;
    logic [SW-1:0] active_ctx;

    always #2.5 clk = ~clk;

    pp_barrel_array #(.NCTX(NCTX), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .pl_en(pl_en), .pl_ctx(pl_ctx), .pl_addr(pl_addr),
        .pl_data(pl_data), .dbg_ctx(dbg_ctx), .dbg_acc(dbg_acc), .dbg_pc(dbg_pc),
        .active_ctx(active_ctx)
    );

    typedef struct {
        logic [AW-1:0] pc;
        logic [11:0]   acc;
        string         tag;
    } exp_t;

    exp_t sbq [NCTX][$];

    logic [11:0]   mmem  [NCTX][DEPTH];
    logic [AW-1:0] m_pc  [NCTX];
    logic [11:0]   m_acc [NCTX];
    logic          m_ph  [NCTX];
    logic [11:0]   m_w0  [NCTX];
    logic [AW-1:0] last_pc  [NCTX];
    logic [11:0]   last_acc [NCTX];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic put_word(input int c, input int a, input logic [11:0] w);
        mmem[c][a] = w;
        @(negedge clk);
        pl_en = 1'b1; pl_ctx = SW'(c); pl_addr = AW'(a); pl_data = w;
        @(negedge clk);
        pl_en = 1'b0;
    endtask

    task automatic load_program(input int c);
        logic [5:0] imm;
        imm = 6'(3 * (c + 1));
        put_word(c, 0,  {6'o01, imm});        // LDI
        put_word(c, 1,  {6'o02, 6'd63});      // ADI
        put_word(c, 2,  {6'o43, 6'o00});      // STM @0C0
        put_word(c, 3,  12'h0C0);
        put_word(c, 4,  {6'o01, 6'd0});       // LDI 0
        put_word(c, 5,  {6'o42, 6'o00});      // ADM @0C0
        put_word(c, 6,  12'h0C0);
        put_word(c, 7,  {6'o42, 6'o00});      // ADM @0C0
        put_word(c, 8,  12'h0C0);
        put_word(c, 9,  {6'o42, 6'o00});      // ADM @0D0, wraps
        put_word(c, 10, 12'h0D0);
        put_word(c, 11, {6'o41, 6'o00});      // LDM @0C0
        put_word(c, 12, 12'h0C0);
        put_word(c, 13, 12'o0000);            // short NOP
        put_word(c, 14, {6'o07, 6'o77});      // undefined short
        put_word(c, 15, {6'o57, 6'o12});      // undefined long
        put_word(c, 16, 12'hABC);
        put_word(c, 17, {6'o02, 6'd5});       // ADI
        put_word(c, 18, {6'o44, 6'o03});      // JMP 18-bit 0x3000 -> 0
        put_word(c, 19, 12'h000);
        put_word(c, 8'hD0, (c % 2 == 1) ? 12'hFFF : 12'h7FF + 12'(c));
    endtask

    // Driver: reference step from the requirements, pushed to the scoreboard.
    task automatic model_step(input int c);
        logic [11:0] w;
        logic [17:0] far;
        logic [AW-1:0] a;
        string tag;
        exp_t e;
        w = mmem[c][m_pc[c]];
        if (!m_ph[c]) begin
            m_pc[c] = m_pc[c] + 1'b1;
            if (w[11]) begin
                m_ph[c] = 1'b1; m_w0[c] = w; tag = "R6";
            end else begin
                case (w[11:6])
                    6'o01: begin m_acc[c] = {6'b0, w[5:0]}; tag = "R4"; end
                    6'o02: begin m_acc[c] = m_acc[c] + {6'b0, w[5:0]}; tag = "R5"; end
                    default: tag = "R11";
                endcase
            end
        end else begin
            far = {m_w0[c][5:0], w};
            a = far[AW-1:0];
            m_ph[c] = 1'b0;
            m_pc[c] = m_pc[c] + 1'b1;
            case (m_w0[c][11:6])
                6'o41: begin m_acc[c] = mmem[c][a]; tag = "R7 R12"; end
                6'o42: begin m_acc[c] = m_acc[c] + mmem[c][a]; tag = "R8 R12"; end
                6'o43: begin mmem[c][a] = m_acc[c]; tag = "R9"; end
                6'o44: begin m_pc[c] = a; tag = "R10 R6"; end
                default: tag = "R11";
            endcase
        end
        e.pc = m_pc[c]; e.acc = m_acc[c]; e.tag = tag;
        sbq[c].push_back(e);
    endtask

    task automatic drive_expectations();
        for (int c = 0; c < NCTX; c++) begin
            m_pc[c] = '0; m_acc[c] = '0; m_ph[c] = 1'b0; m_w0[c] = '0;
            last_pc[c] = '0; last_acc[c] = '0;
        end
        for (int s = 0; s < STEPS; s++)
            for (int c = 0; c < NCTX; c++)
                model_step(c);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < NCTX; c++) load_program(c);
        drive_expectations();
        repeat (2) @(negedge clk);
        // Reset state
        check(active_ctx == 0, "R1", "slot in reset", int'(active_ctx), 0);
        for (int c = 0; c < NCTX; c++) begin
            dbg_ctx = SW'(c);
            #0.1;
            check(dbg_acc == 0 && dbg_pc == 0, "R2", $sformatf("ctx%0d acc/pc", c),
                  int'({dbg_acc, dbg_pc}), 0);
        end
        @(negedge clk);
        rst = 1'b0;
        // Monitor: one executed context per clock.
        for (int k = 0; k < NCTX * STEPS; k++) begin
            int c;
            int o;
            exp_t e;
            c = k % NCTX;
            o = (c + 5) % NCTX;
            @(posedge clk);
            @(negedge clk);
            check(active_ctx == SW'((k + 1) % NCTX), "R1", "slot advance",
                  int'(active_ctx), (k + 1) % NCTX);
            e = sbq[c].pop_front();
            dbg_ctx = SW'(c);
            #0.2;
            check(dbg_acc == e.acc, e.tag, $sformatf("ctx%0d step%0d acc", c, k / NCTX),
                  int'(dbg_acc), int'(e.acc));
            check(dbg_pc == e.pc, e.tag, $sformatf("ctx%0d step%0d pc", c, k / NCTX),
                  int'(dbg_pc), int'(e.pc));
            last_pc[c] = e.pc; last_acc[c] = e.acc;
            dbg_ctx = SW'(o);
            #0.2;
            check(dbg_acc == last_acc[o] && dbg_pc == last_pc[o], "R3",
                  $sformatf("idle ctx%0d held", o),
                  int'({dbg_acc, dbg_pc}), int'({last_acc[o], last_pc[o]}));
        end
        for (int c = 0; c < NCTX; c++)
            check(sbq[c].size() == 0, "R3", $sformatf("ctx%0d queue drained", c),
                  sbq[c].size(), 0);
        done = 1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired: R1 actual=hung expected=done");
            finish_run();
        end
    end

endmodule